// File: doc/BRIEF.md
# Multi-Level Trigger Sequencer

This block turns the strobes of several match units into one ordered trigger. A trigger is not raised on a single match. The block steps through a list of levels instead. Each level names the one strobe it waits for. The sequencer reaches level k+1 only after level k's strobe has been seen. When the strobe of the last level is seen, the block raises a single trigger pulse. It then rests until software re-arms it.

Each level's strobe index is supplied by a static select vector. With two levels, the block can express patterns such as "a valid strobe, and later an edge strobe from a second unit". In that case the second event counts only once the first has occurred. When the level count parameter is zero, the sequencer is bypassed: the trigger follows one selected strobe on every cycle while armed. Match evaluation itself is done elsewhere. This block only orders the results.

Top module: `trig_seq`

## Requirements
- R1: While rst_ni is low, trig_o is 0, level_o is 0 and busy_o is 0.
- R2: While arm_i is low, match strobes have no effect: level_o stays 0, and busy_o and trig_o stay 0.
- R3: One clock after arm_i rises, busy_o is 1 and level_o is 0. level_o counts the levels already satisfied. On each clock edge where arm_i is 1 and the strobe selected for the current level is 1, level_o increases by one. The strobe index for level k is taken from sel_i[k*SEL_W +: SEL_W].
- R4: A strobe that is not selected for the current level does not advance level_o, even if a later level selects it. An index of NUM_MATCH or above never matches.
- R5: The sequencer advances by at most one level per clock, even if the strobes for the current level and the next level are high in the same cycle.
- R6: On the edge where the last level is satisfied, trig_o goes to 1 for exactly one cycle. At the same edge level_o becomes NUM_LEVELS and busy_o becomes 0.
- R7: Once the sequence is complete, further strobes raise no trigger and level_o holds at NUM_LEVELS. This lasts until arm_i has been low for at least one clock and is then raised again.
- R8: One clock after arm_i is sampled low, at any level, level_o is 0, busy_o is 0 and trig_o is 0.
- R9: With NUM_LEVELS = 0, trig_o is registered from (arm_i and the strobe at index sel_i[SEL_W-1:0]). level_o stays 0, and busy_o is arm_i delayed by one clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| arm_i | input | 1 | Arms the sequencer; low clears it to level 0 |
| match_i | input | NUM_MATCH | One strobe per match unit |
| sel_i | input | SLOTS*SEL_W | Per-level strobe index, level k in field k |
| trig_o | output | 1 | Trigger pulse |
| level_o | output | LVL_W | Number of levels satisfied so far |
| busy_o | output | 1 | Armed and sequence not yet complete |

## Verification
The case that is hardest to reach from the ports is a cycle in which the strobes for two consecutive levels are high together, so that an unguarded design would skip a level. The bench reaches it by selecting different strobes for level 0 and level 1 and raising both in one cycle. It checks that level_o moves by one. It then holds every strobe high, so the remaining levels are taken one per clock. There it checks the single-cycle trigger and the hold after completion. A later-level strobe raised while level 0 is pending covers the ordering rule.

// File: rtl/trig_seq_pkg.sv
package trig_seq_pkg;
  function automatic int unsigned clog2_min1(input int unsigned n);
    int unsigned w;
    w = 1;
    while ((1 << w) < n) w++;
    return w;
  endfunction
endpackage

// File: rtl/trig_seq_mux.sv
module trig_seq_mux #(
  parameter int unsigned NUM_MATCH = 4,
  parameter int unsigned SEL_W     = 2
) (
  input  logic [NUM_MATCH-1:0] match_i,
  input  logic [SEL_W-1:0]     idx_i,
  output logic                 hit_o
);
  always_comb begin
    hit_o = 1'b0;
    for (int i = 0; i < NUM_MATCH; i++) begin
      if (idx_i == SEL_W'(i)) hit_o = match_i[i];
    end
  end
endmodule

// File: rtl/trig_seq_fsm.sv
module trig_seq_fsm #(
  parameter int unsigned NUM_LEVELS = 3,
  parameter int unsigned LVL_W      = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             arm_i,
  input  logic             hit_i,
  output logic [LVL_W-1:0] lvl_o,
  output logic             trig_o,
  output logic             busy_o
);
  localparam logic [LVL_W-1:0] LastLvl = LVL_W'(NUM_LEVELS - 1);
  localparam logic [LVL_W-1:0] DoneLvl = LVL_W'(NUM_LEVELS);

  logic [LVL_W-1:0] lvl_q;
  logic             trig_q, arm_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lvl_q  <= '0;
      trig_q <= 1'b0;
      arm_q  <= 1'b0;
    end else begin
      arm_q  <= arm_i;
      trig_q <= 1'b0;
      if (!arm_i) begin
        lvl_q <= '0;
      end else if (lvl_q != DoneLvl && hit_i) begin
        // one level per cycle; completion pulses once and parks
        lvl_q <= lvl_q + 1'b1;
        if (lvl_q == LastLvl) trig_q <= 1'b1;
      end
    end
  end

  assign lvl_o  = lvl_q;
  assign trig_o = trig_q;
  assign busy_o = arm_q && (lvl_q != DoneLvl);
endmodule

// File: rtl/trig_seq.sv
module trig_seq
  import trig_seq_pkg::*;
#(
  parameter int unsigned NUM_MATCH  = 4,
  parameter int unsigned NUM_LEVELS = 3,
  localparam int unsigned SEL_W = clog2_min1(NUM_MATCH),
  localparam int unsigned SLOTS = (NUM_LEVELS == 0) ? 1 : NUM_LEVELS,
  localparam int unsigned LVL_W = clog2_min1(NUM_LEVELS + 1)
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   arm_i,
  input  logic [NUM_MATCH-1:0]   match_i,
  input  logic [SLOTS*SEL_W-1:0] sel_i,
  output logic                   trig_o,
  output logic [LVL_W-1:0]       level_o,
  output logic                   busy_o
);
  logic [SEL_W-1:0] cur_sel;
  logic             hit;

  trig_seq_mux #(.NUM_MATCH(NUM_MATCH), .SEL_W(SEL_W)) u_mux (
    .match_i(match_i),
    .idx_i  (cur_sel),
    .hit_o  (hit)
  );

  generate
    if (NUM_LEVELS == 0) begin : g_bypass
      logic trig_q, arm_q;
      assign cur_sel = sel_i[SEL_W-1:0];
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          trig_q <= 1'b0;
          arm_q  <= 1'b0;
        end else begin
          trig_q <= arm_i && hit;
          arm_q  <= arm_i;
        end
      end
      assign trig_o  = trig_q;
      assign busy_o  = arm_q;
      assign level_o = '0;
    end else begin : g_seq
      logic [SEL_W-1:0] slot_sel [SLOTS];
      logic [LVL_W-1:0] lvl;
      for (genvar k = 0; k < SLOTS; k++) begin : g_slot
        assign slot_sel[k] = sel_i[k*SEL_W +: SEL_W];
      end
      always_comb begin
        cur_sel = '0;
        for (int k = 0; k < SLOTS; k++) begin
          if (lvl == LVL_W'(k)) cur_sel = slot_sel[k];
        end
      end
      trig_seq_fsm #(.NUM_LEVELS(NUM_LEVELS), .LVL_W(LVL_W)) u_fsm (
        .clk_i (clk_i),
        .rst_ni(rst_ni),
        .arm_i (arm_i),
        .hit_i (hit),
        .lvl_o (lvl),
        .trig_o(trig_o),
        .busy_o(busy_o)
      );
      assign level_o = lvl;
    end
  endgenerate
endmodule

// File: rtl/trig_seq_chk.sv
module trig_seq_chk #(
  parameter int unsigned NUM_LEVELS = 3,
  parameter int unsigned LVL_W      = 2
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             arm_i,
  input logic             trig_o,
  input logic [LVL_W-1:0] level_o,
  input logic             busy_o
);
  localparam logic [LVL_W-1:0] DoneLvl = LVL_W'(NUM_LEVELS);

  always_comb begin
    if (!rst_ni) begin
      a_reset_r1: assert (!trig_o && !busy_o && level_o == '0);
    end
  end

  generate
    if (NUM_LEVELS > 0) begin : g_seq
      p_disarm_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !arm_i |=> (level_o == '0 && !busy_o && !trig_o));
      p_one_step_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (level_o != DoneLvl) |=>
          (level_o == $past(level_o) || level_o == $past(level_o) + 1'b1 || level_o == '0));
      p_pulse_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        trig_o |=> !trig_o);
      p_trig_done_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        trig_o |-> (level_o == DoneLvl && !busy_o));
      p_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (level_o == DoneLvl && arm_i) |=> (level_o == DoneLvl && !trig_o));
    end else begin : g_byp
      p_level_zero_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        level_o == '0);
      p_no_trig_disarmed_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !arm_i |=> (!trig_o && !busy_o));
    end
  endgenerate
endmodule

bind trig_seq trig_seq_chk #(.NUM_LEVELS(NUM_LEVELS), .LVL_W(LVL_W)) u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .arm_i  (arm_i),
  .trig_o (trig_o),
  .level_o(level_o),
  .busy_o (busy_o)
);

// File: tb/tb_trig_seq.sv
`timescale 1ns/1ps
module tb_trig_seq;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       arm_i = 1'b0;
  logic [3:0] match_i = '0;
  // level0 -> strobe 2, level1 -> strobe 0, level2 -> strobe 3
  logic [5:0] sel_i = {2'd3, 2'd0, 2'd2};
  logic [1:0] sel_bp = 2'd1;
  logic       trig_o, busy_o, trig_bp, busy_bp;
  logic [1:0] level_o;
  logic [0:0] level_bp;
  int checks = 0, failures = 0;
  bit done = 0;

  always #10 clk_i = ~clk_i;

  trig_seq #(.NUM_MATCH(4), .NUM_LEVELS(3)) dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .arm_i(arm_i), .match_i(match_i),
    .sel_i(sel_i), .trig_o(trig_o), .level_o(level_o), .busy_o(busy_o));

  trig_seq #(.NUM_MATCH(4), .NUM_LEVELS(0)) dut_bp (
    .clk_i(clk_i), .rst_ni(rst_ni), .arm_i(arm_i), .match_i(match_i),
    .sel_i(sel_bp), .trig_o(trig_bp), .level_o(level_bp), .busy_o(busy_bp));

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk_i);
    #5;
  endtask

  task automatic chk_st(input string req, input int lvl, input int trg, input int bsy);
    chk({req, " level"}, level_o, lvl);
    chk({req, " trig"}, trig_o, trg);
    chk({req, " busy"}, busy_o, bsy);
  endtask

  task automatic t_reset();
    #5;
    chk_st("R1", 0, 0, 0);
    chk("R1 bypass trig", trig_bp, 0);
    cyc();
    rst_ni = 1'b1;
    cyc();
  endtask

  task automatic t_idle(); // R2
    arm_i = 1'b0;
    match_i = 4'hF;
    for (int i = 0; i < 3; i++) begin
      cyc();
      chk_st("R2", 0, 0, 0);
    end
    match_i = '0;
  endtask

  task automatic t_sequence(); // R3 R4 R6 R7
    arm_i = 1'b1;
    cyc();
    chk_st("R3 armed", 0, 0, 1);
    match_i = 4'b1011; // later-level strobes only
    cyc();
    chk_st("R4 ordering", 0, 0, 1);
    match_i = 4'b0100;
    cyc();
    chk_st("R3 step1", 1, 0, 1);
    match_i = 4'b0001;
    cyc();
    chk_st("R3 step2", 2, 0, 1);
    match_i = 4'b0100; // not selected at level 2
    cyc();
    chk_st("R4 wrong strobe", 2, 0, 1);
    match_i = 4'b1000;
    cyc();
    chk_st("R6 complete", 3, 1, 0);
    match_i = 4'hF;
    cyc();
    chk_st("R6 pulse ends", 3, 0, 0);
    cyc();
    chk_st("R7 hold", 3, 0, 0);
    match_i = '0;
  endtask

  task automatic t_rearm(); // R7 R8
    arm_i = 1'b0;
    cyc();
    chk_st("R8 disarm", 0, 0, 0);
    arm_i = 1'b1;
    cyc();
    chk_st("R7 rearmed", 0, 0, 1);
  endtask

  task automatic t_simul(); // R5
    match_i = 4'b0101; // level0 and level1 strobes together
    cyc();
    chk_st("R5 single step", 1, 0, 1);
    match_i = 4'hF;
    cyc();
    chk_st("R5 step2", 2, 0, 1);
    cyc();
    chk_st("R5 step3", 3, 1, 0);
    cyc();
    chk_st("R5 after", 3, 0, 0);
    match_i = '0;
  endtask

  task automatic t_abort(); // R8
    arm_i = 1'b0;
    cyc();
    arm_i = 1'b1;
    match_i = 4'b0100;
    cyc();
    match_i = 4'b0001;
    cyc();
    chk_st("R8 mid level", 2, 0, 1);
    match_i = 4'b1000;
    arm_i = 1'b0;
    cyc();
    chk_st("R8 abort", 0, 0, 0);
    match_i = '0;
  endtask

  task automatic t_bypass(); // R9
    arm_i = 1'b1;
    match_i = 4'b0010;
    cyc();
    chk("R9 trig on sel", trig_bp, 1);
    chk("R9 busy", busy_bp, 1);
    cyc();
    chk("R9 trig follows", trig_bp, 1);
    match_i = 4'b1101;
    cyc();
    chk("R9 other strobes", trig_bp, 0);
    chk("R9 level", level_bp, 0);
    match_i = 4'b0010;
    arm_i = 1'b0;
    cyc();
    chk("R9 disarmed", trig_bp, 0);
    chk("R9 busy off", busy_bp, 0);
    match_i = '0;
  endtask

  initial begin
    t_reset();
    t_idle();
    t_sequence();
    t_rearm();
    t_simul();
    t_abort();
    t_bypass();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    #1000000;
    if (!done) begin
      done = 1;
      checks++;
      failures++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule